// File: doc/BRIEF.md
# Character Bridge with Threshold Interrupts

This block moves bytes between a processor and a host. It holds two byte queues. The inbound queue is filled by the host and drained by the processor. The outbound queue is filled by the processor and drained by the host. The host side is a plain valid/ready byte stream in each direction. It also has a poll strobe and an end-of-stream level, which the host uses to say that no further bytes will arrive. The processor side is a single-cycle memory-mapped slave with two registers: a data register (address 0) and a control register (address 1).

A level interrupt can be raised for each queue. The inbound queue raises it when its remaining free space drops to the inbound threshold or below. The outbound queue raises it when its fill level drops to the outbound threshold or below. Software therefore learns that the inbound queue is nearly full, or that the outbound queue is nearly empty, before either reaches its limit. A sticky activity flag records that the host has polled the block.

Read data is combinational from the current state and is valid in the same cycle as the address. A read of the data register removes one byte at the next rising edge.

Top module: `char_bridge`

## Requirements
- R1: After reset both queues are empty, both interrupt enables are 0, the activity flag is 0, `irq` is low, `host_in_ready` is high and `host_out_valid` is low.
- R2: Each queue holds 2^AW bytes, with AW from 3 to 15 and a default of 6 (64 bytes). `host_in_ready` is low exactly when the inbound queue is full, and a host byte offered while it is full is not stored.
- R3: Reading address 0 returns the oldest inbound byte in bits 7:0 (0 when the queue is empty), a valid flag in bit 15, and the inbound fill count in bits 31:16. When the valid flag is set, the read removes that byte.
- R4: Writing address 0 appends bits 7:0 to the outbound queue. The write is discarded when the outbound queue is full.
- R5: `host_out_valid` is high whenever the outbound queue is non-empty. `host_out_data` presents the bytes in the order they were written, and a byte leaves when `host_out_ready` is high.
- R6: The inbound pending flag is set while the inbound free space (2^AW minus the fill count) is at or below RD_THRESH, which defaults to 8.
- R7: The inbound pending flag is also set while `host_eos` is high and the inbound queue holds at least one byte.
- R8: The outbound pending flag is set while the outbound fill count is at or below WR_THRESH, which defaults to 8.
- R9: Reading address 1 returns the inbound enable in bit 0, the outbound enable in bit 1, the inbound pending flag in bit 8, the outbound pending flag in bit 9, the activity flag in bit 10 and the outbound free space in bits 31:16. All other bits read 0. Writing address 1 loads bits 1:0 into the enables.
- R10: A `host_poll` pulse sets the activity flag. Writing address 1 with bit 10 set clears the flag. When both happen in the same cycle, the set wins.
- R11: `irq` is high exactly when some pending flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` |
| host_in_valid | input | 1 | Host offers an inbound byte |
| host_in_data | input | 8 | Inbound byte |
| host_in_ready | output | 1 | Inbound queue can accept a byte |
| host_out_valid | output | 1 | Outbound byte available |
| host_out_data | output | 8 | Oldest outbound byte |
| host_out_ready | input | 1 | Host takes the outbound byte |
| host_poll | input | 1 | Host poll strobe that sets the activity flag |
| host_eos | input | 1 | Host will send no further bytes |
| irq | output | 1 | Level interrupt |

## Verification
`bus_rdata`, `irq`, `host_in_ready`, `host_out_valid` and `host_out_data` are combinational functions of the stored state. They are therefore due in the same cycle as the address or the state they reflect. A bus or host action changes that state at the next rising edge, so its effect first shows one cycle later. The bench drives inputs on the falling edge and compares the combinational outputs 1 ns later against a queue model. It then advances the model at the rising edge together with the design. This keeps every comparison exactly one state update behind the stimulus that caused it.

// File: rtl/char_bridge_pkg.sv
package char_bridge_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int BIT_RD_EN   = 0;
  localparam int BIT_WR_EN   = 1;
  localparam int BIT_RD_PEND = 8;
  localparam int BIT_WR_PEND = 9;
  localparam int BIT_ACT     = 10;
  localparam int BIT_VALID   = 15;
  typedef struct packed {
    logic wr;
    logic rd;
  } pend_t;
endpackage

// File: rtl/chr_fifo.sv
module chr_fifo #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = wptr_q + 1'b1;
    if (do_pop)  rptr_d = rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R4
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/chr_ctrl.sv
module chr_ctrl
  import char_bridge_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int unsigned RD_THRESH = 8,
  parameter int unsigned WR_THRESH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [1:0]  en_wdata,
  input  logic        act_clr,
  input  logic        poll,
  input  logic [AW:0] rd_count,
  input  logic [AW:0] wr_count,
  input  logic        eos,
  output logic [1:0]  en,
  output logic        act,
  output pend_t       pend,
  output logic        irq
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic [1:0]    en_q, en_d;
  logic          act_q, act_d;
  logic [CW-1:0] rd_free;

  assign rd_free = CW'(DEPTH) - rd_count;

  always_comb begin
    en_d  = en_q;
    act_d = act_q;
    if (ctrl_we) begin
      en_d = en_wdata;
      if (act_clr) act_d = 1'b0;
    end
    if (poll) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    pend.rd = (32'(rd_free) <= RD_THRESH) || (eos && (rd_count != '0));
    pend.wr = (32'(wr_count) <= WR_THRESH);
  end

  assign en  = en_q;
  assign act = act_q;
  assign irq = (pend.rd && en_q[0]) || (pend.wr && en_q[1]);

  // R10
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll |=> act_q);

  // R10
  act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && act_clr && !poll) |=> !act_q);

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 2'b00) |-> !irq);
endmodule

// File: rtl/char_bridge.sv
module char_bridge
  import char_bridge_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int unsigned RD_THRESH = 8,
  parameter int unsigned WR_THRESH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        host_in_valid,
  input  logic [7:0]  host_in_data,
  output logic        host_in_ready,
  output logic        host_out_valid,
  output logic [7:0]  host_out_data,
  input  logic        host_out_ready,
  input  logic        host_poll,
  input  logic        host_eos,
  output logic        irq
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic          rd_full, rd_empty, wr_full, wr_empty;
  logic [CW-1:0] rd_count, wr_count;
  logic [7:0]    rd_head;
  logic          data_rd, data_wr, ctrl_wr;
  logic [1:0]    en;
  logic          act;
  pend_t         pend;
  logic [31:0]   data_word, ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign data_rd = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
  assign data_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
  assign ctrl_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_CTRL);

  chr_fifo #(.AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_i_n),
    .push(host_in_valid), .din(host_in_data),
    .pop(data_rd), .dout(rd_head),
    .count(rd_count), .full(rd_full), .empty(rd_empty)
  );

  chr_fifo #(.AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_i_n),
    .push(data_wr), .din(bus_wdata[7:0]),
    .pop(host_out_ready), .dout(host_out_data),
    .count(wr_count), .full(wr_full), .empty(wr_empty)
  );

  chr_ctrl #(.AW(AW), .RD_THRESH(RD_THRESH), .WR_THRESH(WR_THRESH)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .ctrl_we(ctrl_wr), .en_wdata(bus_wdata[1:0]), .act_clr(bus_wdata[BIT_ACT]),
    .poll(host_poll), .rd_count(rd_count), .wr_count(wr_count), .eos(host_eos),
    .en(en), .act(act), .pend(pend), .irq(irq)
  );

  assign host_in_ready  = !rd_full;
  assign host_out_valid = !wr_empty;

  always_comb begin
    data_word = '0;
    data_word[31:16]    = 16'(rd_count);
    data_word[BIT_VALID] = !rd_empty;
    data_word[7:0]      = rd_empty ? 8'h00 : rd_head;
    ctrl_word = '0;
    ctrl_word[31:16]       = 16'(CW'(DEPTH) - wr_count);
    ctrl_word[BIT_ACT]     = act;
    ctrl_word[BIT_WR_PEND] = pend.wr;
    ctrl_word[BIT_RD_PEND] = pend.rd;
    ctrl_word[BIT_WR_EN]   = en[1];
    ctrl_word[BIT_RD_EN]   = en[0];
  end

  assign bus_rdata = (bus_addr == ADDR_CTRL) ? ctrl_word : data_word;

  // R7
  eos_pend_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (host_eos && !rd_empty) |-> pend.rd);

  // R5
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    host_out_valid |-> (wr_count != '0));

  // R2
  in_ready_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!host_in_ready && !data_rd) |=> !host_in_ready);
endmodule

// File: tb/char_bridge_bench.sv
module char_bridge_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int TH    = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        host_in_valid, host_in_ready, host_out_valid, host_out_ready;
  logic [7:0]  host_in_data, host_out_data;
  logic        host_poll, host_eos, irq;

  always #5 clk = ~clk;

  char_bridge #(.AW(AW), .RD_THRESH(TH), .WR_THRESH(TH)) u_char_bridge (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_in_valid(host_in_valid), .host_in_data(host_in_data), .host_in_ready(host_in_ready),
    .host_out_valid(host_out_valid), .host_out_data(host_out_data), .host_out_ready(host_out_ready),
    .host_poll(host_poll), .host_eos(host_eos), .irq(irq)
  );

  int unsigned compared = 0;
  int unsigned mismatched = 0;
  bit          done = 0;

  byte unsigned rq[$];
  byte unsigned wq[$];
  bit [1:0]     m_en;
  bit           m_act;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act_v, exp_v);
    end
  endtask

  function automatic bit f_rpend();
    return ((DEPTH - rq.size()) <= TH) || (host_eos && rq.size() > 0);
  endfunction

  function automatic bit f_wpend();
    return wq.size() <= TH;
  endfunction

  function automatic logic [31:0] f_data();
    logic [31:0] v = '0;
    v[31:16] = 16'(rq.size());
    v[15]    = rq.size() > 0;
    v[7:0]   = rq.size() > 0 ? rq[0] : 8'h00;
    return v;
  endfunction

  function automatic logic [31:0] f_ctrl();
    logic [31:0] v = '0;
    v[31:16] = 16'(DEPTH - wq.size());
    v[10] = m_act; v[9] = f_wpend(); v[8] = f_rpend(); v[1:0] = m_en;
    return v;
  endfunction

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
    host_in_valid = 0; host_in_data = '0; host_out_ready = 0; host_poll = 0;
  endtask

  // Called at a falling edge after inputs are set; returns at the next falling edge.
  task automatic tick();
    bit rd_pop, wr_push, hin, hout;
    logic [31:0] e;
    #1;
    chk(irq === ((f_rpend() && m_en[0]) || (f_wpend() && m_en[1])), "R11", "irq", 32'(irq),
        32'((f_rpend() && m_en[0]) || (f_wpend() && m_en[1])));
    chk(host_in_ready === (rq.size() < DEPTH), "R2", "host_in_ready", 32'(host_in_ready),
        32'(rq.size() < DEPTH));
    chk(host_out_valid === (wq.size() > 0), "R5", "host_out_valid", 32'(host_out_valid),
        32'(wq.size() > 0));
    if (wq.size() > 0)
      chk(host_out_data === wq[0], "R5", "host_out_data", 32'(host_out_data), 32'(wq[0]));
    if (bus_sel && !bus_wr && !bus_addr) begin
      e = f_data();
      chk(bus_rdata === e, "R3", "data read", bus_rdata, e);
    end
    if (bus_sel && !bus_wr && bus_addr) begin
      e = f_ctrl();
      chk(bus_rdata[8] === e[8], (host_eos && rq.size() > 0 && (DEPTH - rq.size()) > TH) ? "R7" : "R6",
          "rd pending", 32'(bus_rdata[8]), 32'(e[8]));
      chk(bus_rdata[9] === e[9], "R8", "wr pending", 32'(bus_rdata[9]), 32'(e[9]));
      chk(bus_rdata[10] === e[10], "R10", "activity", 32'(bus_rdata[10]), 32'(e[10]));
      chk(bus_rdata === e, "R9", "ctrl read", bus_rdata, e);
    end
    rd_pop  = bus_sel && !bus_wr && !bus_addr && rq.size() > 0;
    wr_push = bus_sel && bus_wr && !bus_addr && wq.size() < DEPTH;
    hin     = host_in_valid && rq.size() < DEPTH;
    hout    = host_out_ready && wq.size() > 0;
    @(posedge clk);
    if (rd_pop)  void'(rq.pop_front());
    if (hin)     rq.push_back(host_in_data);
    if (hout)    void'(wq.pop_front());
    if (wr_push) wq.push_back(bus_wdata[7:0]);
    if (bus_sel && bus_wr && bus_addr) begin
      m_en = bus_wdata[1:0];
      if (bus_wdata[10]) m_act = 0;
    end
    if (host_poll) m_act = 1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    int unsigned r, pin, prd, pwr, pout;
    void'($urandom(32'd4711));
    idle(); host_eos = 0; rst_n = 0; m_en = 0; m_act = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    bus_addr = 1;
    #1;
    chk(bus_rdata === 32'h0040_0200, "R1", "ctrl after reset", bus_rdata, 32'h0040_0200);
    chk(irq === 1'b0, "R1", "irq after reset", 32'(irq), 0);
    chk(host_in_ready === 1'b1 && host_out_valid === 1'b0, "R1", "host flags after reset",
        {host_in_ready, host_out_valid}, 32'h2);
    @(negedge clk); idle();

    // R10 poll sets, poll+clear keeps set, clear alone clears
    host_poll = 1; tick();
    bus_sel = 1; bus_addr = 1; tick();
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h400; host_poll = 1; tick();
    bus_sel = 1; bus_addr = 1; tick();
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h403; tick();
    bus_sel = 1; bus_addr = 1; tick();

    // R4 overfill the outbound queue, then count drained bytes
    for (int i = 0; i < DEPTH + 6; i++) begin
      bus_sel = 1; bus_wr = 1; bus_wdata = 32'(i + 8'h30); tick();
    end
    bus_sel = 1; bus_addr = 1; tick();
    n = 0;
    for (int i = 0; i < DEPTH + 6; i++) begin
      #0;
      if (host_out_valid) n++;
      host_out_ready = 1; tick();
    end
    chk(n == DEPTH, "R4", "bytes accepted by full outbound queue", 32'(n), 32'(DEPTH));

    // R2 / R6 overfill the inbound queue
    for (int i = 0; i < DEPTH + 6; i++) begin
      host_in_valid = 1; host_in_data = 8'(8'hA0 + i);
      if (i % 8 == 0) begin bus_sel = 1; bus_addr = 1; end
      tick();
    end
    for (int i = 0; i < DEPTH - 2; i++) begin
      bus_sel = 1; bus_addr = (i % 4 == 3); tick();
    end
    // R7 end of stream with few bytes left
    host_eos = 1;
    bus_sel = 1; bus_addr = 1; tick();
    bus_sel = 1; tick();
    bus_sel = 1; bus_addr = 1; tick();
    bus_sel = 1; tick();
    bus_sel = 1; bus_addr = 1; tick();
    host_eos = 0;

    // Random phases
    for (int i = 0; i < 3000; i++) begin
      case (i / 1000)
        0: begin pin = 80; prd = 10; pwr = 10; pout = 20; end
        1: begin pin = 20; prd = 20; pwr = 60; pout = 15; end
        default: begin pin = 40; prd = 30; pwr = 30; pout = 40; end
      endcase
      if ($urandom_range(99) < 3) host_eos = ~host_eos;
      host_in_valid  = $urandom_range(99) < pin;
      host_in_data   = 8'($urandom);
      host_out_ready = $urandom_range(99) < pout;
      host_poll      = $urandom_range(99) < 5;
      r = $urandom_range(99);
      bus_wdata = $urandom;
      if (r < prd) begin bus_sel = 1; bus_addr = 0; end
      else if (r < prd + pwr) begin bus_sel = 1; bus_wr = 1; bus_addr = 0; end
      else if (r < prd + pwr + 15) begin bus_sel = 1; bus_addr = 1; end
      else if (r < prd + pwr + 20) begin bus_sel = 1; bus_wr = 1; bus_addr = 1; end
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule